// File: doc/BRIEF.md
# Wake Source Flag Register

This block is a 16-bit status and control word that tells software which event woke the device from its deepest low-power state. Eight external interrupt lines, a non-maskable interrupt and a manual reset pin each own one flag bit. A flag is captured only while the block is in deep standby. The first wake event ends standby inside the block, so only the event or events of that one cycle are recorded.

The top bit is a pin-retention control. It sets by itself when deep standby is entered, and while it is 1 the pads keep their frozen state. Software clears flags and the retention bit with a guarded sequence. It must first read the word through a full 16-bit access and see the bit as 1. A later full-word write of 0 to that bit then clears it.

A power-on reset wipes the word. The reset that follows a wake-up by interrupt or manual reset leaves the word intact, so software can inspect it afterwards.

Top module: `wake_flag_reg`

## Requirements
- R1: While `por_n` is low, the word reads 0x0000 and `pin_hold` is 0. Afterwards it still reads 0x0000 until some event sets a bit.
- R2: Read layout: bit 15 is retention, bit 9 is the manual reset flag, bit 8 is the NMI flag, and bits 7..0 are the IRQ flags 7..0. Bits 14..10 always read 0, whatever value was written to them.
- R3: A `dstby_enter` pulse sets bit 15 at the next clock edge and puts the block into deep standby.
- R4: Wake events arriving while the block is not in deep standby set no flag.
- R5: In deep standby, each wake event in a cycle sets its own flag at the next edge. That cycle ends standby, so events in later cycles are not captured.
- R6: A full-word write of 0 clears a bit only if an earlier full-word read returned 1 for that bit. Writing 0 without such a read, or writing 1, leaves the bit unchanged, and writing 1 never sets a bit.
- R7: A clearing write uses up that bit's read permission. If the bit is set again later, a write of 0 has no effect until a new full-word read has returned 1.
- R8: Narrow accesses (`bus_word` low) have no effect. A narrow read grants no clear permission, and a narrow write changes no bit.
- R9: A `rst_wake` pulse keeps the word's contents and takes away every pending read permission.
- R10: If a wake event sets a bit in the same cycle that a permitted write clears it, the bit ends up 1.
- R11: `pin_hold` always equals bit 15 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears the word |
| rst_wake | input | 1 | Synchronous wake-up reset; keeps the word and drops read permissions |
| irq_ev | input | 8 | External interrupt wake events, one per line |
| nmi_ev | input | 1 | Non-maskable interrupt wake event |
| mres_ev | input | 1 | Manual reset pin wake event |
| dstby_enter | input | 1 | Strobe marking entry into deep standby |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | High when the access is a full 16-bit word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Register contents |
| pin_hold | output | 1 | Pad state retention control |

## Verification
The capture logic is exercised with single events, with several events arriving together, and with events that fall outside standby or after the first wake cycle. Together these show per-source capture, gating by the standby state, and the end of standby on the first wake. The clear logic is exercised with several access patterns: a write without a prior read, a write of ones, a narrow read or write, a write after a wake reset, and a second write after the permission has been used. Each of these separates a correct read-then-write guard from a plain write-to-clear or a sticky permission. One cycle combines a wake event and a clearing write on the same bit to show that the set takes priority.

// File: rtl/wake_flag_reg.sv
module wake_flag_reg #(
  parameter int IRQ_N = 8
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_wake,
  input  logic [IRQ_N-1:0]    irq_ev,
  input  logic                nmi_ev,
  input  logic                mres_ev,
  input  logic                dstby_enter,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic                bus_word,
  input  logic [15:0]         bus_wdata,
  output logic [15:0]         bus_rdata,
  output logic                pin_hold
);
  localparam int W      = 16;
  localparam int NMI_B  = IRQ_N;
  localparam int MRES_B = IRQ_N + 1;
  localparam int HOLD_B = W - 1;
  localparam logic [W-1:0] HOLD_M = W'(1) << HOLD_B;
  localparam logic [W-1:0] EV_M   = (W'(1) << (MRES_B + 1)) - W'(1);
  localparam logic [W-1:0] IMPL_M = HOLD_M | EV_M;

  logic [W-1:0] word_q, perm_q;
  logic         stby_q;

  logic [W-1:0] ev_vec, set_v, clr_v;
  logic         wr_full, rd_full, any_ev;

  assign ev_vec  = W'({mres_ev, nmi_ev, irq_ev});
  assign any_ev  = |ev_vec;
  assign wr_full = bus_wr & bus_word;
  assign rd_full = bus_rd & bus_word;
  assign set_v   = (stby_q ? (ev_vec & EV_M) : '0) | (dstby_enter ? HOLD_M : '0);
  assign clr_v   = wr_full ? (perm_q & ~bus_wdata & IMPL_M) : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      word_q <= '0;
      perm_q <= '0;
      stby_q <= 1'b0;
    end else begin
      word_q <= (word_q & ~clr_v) | set_v;
      if (rst_wake)
        perm_q <= '0;
      else
        perm_q <= (perm_q & ~clr_v) | (rd_full ? (word_q & IMPL_M) : '0);
      if (rst_wake)
        stby_q <= 1'b0;
      else if (stby_q && any_ev)
        stby_q <= 1'b0;
      else if (dstby_enter)
        stby_q <= 1'b1;
    end
  end

  assign bus_rdata = word_q;
  assign pin_hold  = word_q[HOLD_B];

  // R3
  hold_on_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
    dstby_enter |=> pin_hold);

  // R4
  flag_needs_event_chk: assert property (@(posedge clk) disable iff (!por_n)
    ((word_q & ~$past(word_q) & EV_M & ~($past(ev_vec) & {W{$past(stby_q)}})) == '0));

  // R6
  clear_needs_write_chk: assert property (@(posedge clk) disable iff (!por_n)
    !wr_full |=> ((~word_q & $past(word_q)) == '0));

  // R8
  narrow_write_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bus_wr && !bus_word && !stby_q && !dstby_enter) |=> $stable(bus_rdata));

  // R9
  wake_reset_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rst_wake && !stby_q && !dstby_enter && !bus_wr) |=> $stable(bus_rdata));
endmodule

// File: tb/wake_flag_reg_test.sv
module wake_flag_reg_test;
  logic        clk = 0;
  logic        por_n = 0, rst_wake = 0;
  logic [7:0]  irq_ev = '0;
  logic        nmi_ev = 0, mres_ev = 0, dstby_enter = 0;
  logic        bus_rd = 0, bus_wr = 0, bus_word = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pin_hold;
  int checks = 0, errors = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  wake_flag_reg uut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic rd(input logic word, output logic [15:0] v);
    bus_rd = 1; bus_word = word; v = bus_rdata;
    cyc();
    bus_rd = 0; bus_word = 0;
  endtask

  task automatic wr(input logic [15:0] d, input logic word);
    bus_wr = 1; bus_word = word; bus_wdata = d;
    cyc();
    bus_wr = 0; bus_word = 0; bus_wdata = '0;
  endtask

  task automatic enter();
    dstby_enter = 1; cyc(); dstby_enter = 0;
  endtask

  task automatic ev(input logic [7:0] i, input logic n, input logic m);
    irq_ev = i; nmi_ev = n; mres_ev = m; cyc();
    irq_ev = '0; nmi_ev = 0; mres_ev = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset word", bus_rdata, 16'h0000);
    chk("R11 reset hold", {15'b0, pin_hold}, 16'h0000);
    por_n = 1; cyc();
    chk("R1 after release", bus_rdata, 16'h0000);
  endtask

  task automatic t_outside();
    ev(8'h08, 1, 1);
    chk("R4 events outside standby", bus_rdata, 16'h0000);
  endtask

  task automatic t_capture();
    enter();
    chk("R3 entry sets hold", bus_rdata, 16'h8000);
    chk("R11 hold pin", {15'b0, pin_hold}, 16'h0001);
    ev(8'h20, 0, 0);
    chk("R5 irq5 captured", bus_rdata, 16'h8020);
    ev(8'h00, 1, 0);
    chk("R5 later event not captured", bus_rdata, 16'h8020);
  endtask

  task automatic t_guard();
    wr(16'h0000, 1);
    chk("R6 write 0 without read", bus_rdata, 16'h8020);
    rd(0, rv);
    wr(16'h0000, 0);
    chk("R8 narrow write", bus_rdata, 16'h8020);
    wr(16'h0000, 1);
    chk("R8 narrow read grants nothing", bus_rdata, 16'h8020);
    wr(16'hFFFF, 1);
    chk("R6 write ones", bus_rdata, 16'h8020);
    wr(16'h7C00, 1);
    chk("R2 reserved read zero", bus_rdata & 16'h7C00, 16'h0000);
  endtask

  task automatic t_clear();
    rd(1, rv);
    chk("R2 read value", rv, 16'h8020);
    wr(16'h8000, 1);
    chk("R6 clear irq5 keep hold", bus_rdata, 16'h8000);
    chk("R11 hold still set", {15'b0, pin_hold}, 16'h0001);
    wr(16'h0000, 1);
    chk("R6 clear hold", bus_rdata, 16'h0000);
    chk("R11 hold released", {15'b0, pin_hold}, 16'h0000);
  endtask

  task automatic t_consumed();
    enter(); ev(8'h00, 0, 1);
    chk("R5 mres captured", bus_rdata, 16'h8200);
    rd(1, rv); wr(16'h0000, 1);
    chk("R6 clear both", bus_rdata, 16'h0000);
    enter(); ev(8'h00, 0, 1);
    wr(16'h0000, 1);
    chk("R7 permission used up", bus_rdata, 16'h8200);
  endtask

  task automatic t_wake_reset();
    rd(1, rv);
    rst_wake = 1; cyc(); rst_wake = 0;
    chk("R9 contents kept", bus_rdata, 16'h8200);
    wr(16'h0000, 1);
    chk("R9 permission dropped", bus_rdata, 16'h8200);
    rd(1, rv); wr(16'h0000, 1);
    chk("R6 clear after new read", bus_rdata, 16'h0000);
  endtask

  task automatic t_multi();
    enter(); ev(8'h81, 1, 0);
    chk("R5 simultaneous events", bus_rdata, 16'h8181);
  endtask

  task automatic t_set_wins();
    rd(1, rv);
    enter();
    irq_ev = 8'h01; bus_wr = 1; bus_word = 1; bus_wdata = 16'h0000;
    cyc();
    irq_ev = '0; bus_wr = 0; bus_word = 0;
    chk("R10 set beats clear", bus_rdata, 16'h0001);
    chk("R11 hold follows bit", {15'b0, pin_hold}, 16'h0000);
  endtask

  task automatic t_por();
    enter(); ev(8'h04, 0, 0);
    por_n = 0; #3;
    chk("R1 power-on clears", bus_rdata, 16'h0000);
    cyc(); por_n = 1; cyc();
    chk("R1 stays clear", bus_rdata, 16'h0000);
  endtask

  initial begin
    cyc(); cyc();
    t_reset();
    t_outside();
    t_capture();
    t_guard();
    t_clear();
    t_consumed();
    t_wake_reset();
    t_multi();
    t_set_wins();
    t_por();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule